// File: doc/BRIEF.md
# Wake Event Controller

This block handles the aftermath of a wake-up frame on a network controller that sits in a low-power mode. A separate frame detector sends a one-cycle detection pulse. While wake mode is armed, that pulse sets three sticky status flags. The flags are a match flag, a wake-interrupt flag and a power-management status flag. From these flags the block drives a power-management event output, an interrupt output and an LED indication. Each of those outputs is gated by its own enables.

A detection also produces a one-cycle discard pulse, so that the receive path drops the frame. It also raises a pause towards the transmit and receive engines. The pause holds until the host shows it is awake: either the power-good input goes high or software clears the wake-mode enable. The engines then continue from where they stopped, because nothing here touches their descriptor positions.

The two ways out of wake mode re-arm differently. After power-good has been high, wake mode re-arms only once power-good has stayed low for a minimum time. That time is 200 ns, expressed as a cycle count derived from the clock period. After software has cleared the enable, setting it again re-arms on the next cycle.

Top module: `wol_event_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, every flag, `pause_o`, `frame_drop_o`, `pme_o`, `irq_o`, `led_o`, `wake_armed_o` and the re-arm counter are cleared to 0.
- R2: A `det_pulse_i` sampled while `wake_armed_o` is 1 sets `match_flag_o`, `wint_flag_o` and `pms_flag_o` at that edge. A pulse sampled while `wake_armed_o` is 0 changes no flag and no other output.
- R3: Each flag stays set until its own clear strobe is sampled high. A clear strobe and an armed detection in the same cycle leave the flag set.
- R4: `pme_o` is 1 exactly when the power-management status flag is set and at least one of `pme_en_i` and `pme_ovr_i` is 1. It is registered and updates on the same edge as the flag.
- R5: `irq_o` is 1 exactly when the wake-interrupt flag is set and both `irq_en_i` and `wint_en_i` are 1. It is registered and updates on the same edge as the flag.
- R6: The LED condition is `led_sel_i` AND the match flag. When `led_pol_i` is 1, `led_o` equals the condition (active high). When `led_pol_i` is 0, `led_o` equals its inverse (active low).
- R7: `frame_drop_o` is a one-cycle pulse at the edge that samples an armed detection. It is 0 at every other edge.
- R8: An armed detection raises `pause_o`. `pause_o` stays high until an edge samples `pwr_good_i` high or `wake_en_i` low. Release wins over a detection in the same cycle.
- R9: `wake_armed_o` needs `wake_en_i` high and `pwr_good_i` low. It rises on the (MIN_LOW_CYC+1)-th consecutive edge at which `pwr_good_i` is sampled low. At the defaults (4000 ps clock, 200 ns) MIN_LOW_CYC is 50. Any high sample of power-good restarts the count.
- R10: If power-good has already been low long enough, clearing `wake_en_i` and then setting it again gives `wake_armed_o` = 1 at the first edge that samples the enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_en_i | input | 1 | Software wake-mode enable |
| pwr_good_i | input | 1 | Host power-good indication |
| det_pulse_i | input | 1 | One-cycle wake-frame detection pulse |
| clr_match_i | input | 1 | Write-one-to-clear strobe for the match flag |
| clr_wint_i | input | 1 | Write-one-to-clear strobe for the wake-interrupt flag |
| clr_pms_i | input | 1 | Write-one-to-clear strobe for the power-management status flag |
| pme_en_i | input | 1 | Power-management event enable |
| pme_ovr_i | input | 1 | Power-management event override enable |
| irq_en_i | input | 1 | Global interrupt enable |
| wint_en_i | input | 1 | Wake-interrupt enable |
| led_sel_i | input | 1 | Route the wake indication to the LED |
| led_pol_i | input | 1 | LED polarity, 1 = active high |
| match_flag_o | output | 1 | Sticky match-detected flag |
| wint_flag_o | output | 1 | Sticky wake-interrupt flag |
| pms_flag_o | output | 1 | Sticky power-management status flag |
| pme_o | output | 1 | Power-management event output |
| irq_o | output | 1 | Interrupt output |
| led_o | output | 1 | LED wake indication |
| frame_drop_o | output | 1 | Discard pulse for the detected frame |
| pause_o | output | 1 | Hold for the transmit and receive engines |
| wake_armed_o | output | 1 | Wake mode is armed |

## Verification
Every flag, the gated outputs, the discard pulse and the pause respond at the rising edge that samples the stimulus, one cycle after the input is driven. The armed state is the exception: it follows MIN_LOW_CYC+1 low samples of power-good, or one edge after the enable rises. The driver applies inputs just after a falling edge. At the next rising edge it computes the expected outputs and queues them. A monitor then compares each queued item at the following falling edge, so every comparison lands exactly one register stage after its cause.

// File: rtl/wol_evt_pkg.sv
package wol_evt_pkg;

  localparam int NUM_FLAGS = 3;
  localparam int IDX_MATCH = 0;
  localparam int IDX_WINT  = 1;
  localparam int IDX_PMS   = 2;

  // Round a time in nanoseconds up to whole clock cycles.
  function automatic int min_low_cycles(input int min_ns, input int clk_ps);
    return (min_ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/wol_rearm_timer.sv
module wol_rearm_timer #(
  parameter int MIN_CYC = 50,
  parameter int CNT_W   = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good_i,
  output logic low_ok_o
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_CYC);

  logic [CNT_W-1:0] low_cnt;

  // Count consecutive low samples of power-good, saturating at the limit.
  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
    end else if (pwr_good_i) begin
      low_cnt <= '0;
    end else if (low_cnt != LIMIT) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign low_ok_o = (low_cnt == LIMIT);

  AST_PG_RESTARTS_TIMER: assert property (@(posedge clk) disable iff (rst)
    pwr_good_i |=> !low_ok_o); // R9

endmodule

// File: rtl/wol_sticky_flag.sv
module wol_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_nxt_o,
  output logic flag_o
);

  // A set in the same cycle as a clear takes priority.
  always_comb begin
    flag_nxt_o = (flag_o & ~clr_i) | set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= flag_nxt_o;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o); // R3

endmodule

// File: rtl/wol_out_gate.sv
module wol_out_gate (
  input  logic clk,
  input  logic rst,
  input  logic match_nxt_i,
  input  logic wint_nxt_i,
  input  logic pms_nxt_i,
  input  logic pme_en_i,
  input  logic pme_ovr_i,
  input  logic irq_en_i,
  input  logic wint_en_i,
  input  logic led_sel_i,
  input  logic led_pol_i,
  output logic pme_o,
  output logic irq_o,
  output logic led_o
);

  logic led_act;

  assign led_act = led_sel_i & match_nxt_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pme_o <= 1'b0;
      irq_o <= 1'b0;
      led_o <= 1'b0;
    end else begin
      pme_o <= pms_nxt_i & (pme_en_i | pme_ovr_i);
      irq_o <= wint_nxt_i & irq_en_i & wint_en_i;
      led_o <= led_pol_i ? led_act : ~led_act;
    end
  end

  AST_PME_GATED: assert property (@(posedge clk) disable iff (rst)
    !(pme_en_i || pme_ovr_i) |=> !pme_o); // R4

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !(irq_en_i && wint_en_i) |=> !irq_o); // R5

  AST_LED_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !led_sel_i |=> (led_o == !$past(led_pol_i))); // R6

endmodule

// File: rtl/wol_event_ctrl.sv
module wol_event_ctrl
  import wol_evt_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int MIN_LOW_NS    = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic wake_en_i,
  input  logic pwr_good_i,
  input  logic det_pulse_i,
  input  logic clr_match_i,
  input  logic clr_wint_i,
  input  logic clr_pms_i,
  input  logic pme_en_i,
  input  logic pme_ovr_i,
  input  logic irq_en_i,
  input  logic wint_en_i,
  input  logic led_sel_i,
  input  logic led_pol_i,
  output logic match_flag_o,
  output logic wint_flag_o,
  output logic pms_flag_o,
  output logic pme_o,
  output logic irq_o,
  output logic led_o,
  output logic frame_drop_o,
  output logic pause_o,
  output logic wake_armed_o
);

  localparam int MIN_LOW_CYC = min_low_cycles(MIN_LOW_NS, CLK_PERIOD_PS);
  localparam int CNT_W       = $clog2(MIN_LOW_CYC + 1);

  logic                 low_ok;
  logic                 hit;
  logic                 release_req;
  logic [NUM_FLAGS-1:0] clr_vec;
  logic [NUM_FLAGS-1:0] flag_nxt;
  logic [NUM_FLAGS-1:0] flag_q;

  wol_rearm_timer #(
    .MIN_CYC (MIN_LOW_CYC),
    .CNT_W   (CNT_W)
  ) timer_i (
    .clk        (clk),
    .rst        (rst),
    .pwr_good_i (pwr_good_i),
    .low_ok_o   (low_ok)
  );

  assign hit         = wake_armed_o & det_pulse_i;
  assign release_req = pwr_good_i | ~wake_en_i;

  always_comb begin
    clr_vec            = '0;
    clr_vec[IDX_MATCH] = clr_match_i;
    clr_vec[IDX_WINT]  = clr_wint_i;
    clr_vec[IDX_PMS]   = clr_pms_i;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    wol_sticky_flag flag_i (
      .clk        (clk),
      .rst        (rst),
      .set_i      (hit),
      .clr_i      (clr_vec[g]),
      .flag_nxt_o (flag_nxt[g]),
      .flag_o     (flag_q[g])
    );
  end

  assign match_flag_o = flag_q[IDX_MATCH];
  assign wint_flag_o  = flag_q[IDX_WINT];
  assign pms_flag_o   = flag_q[IDX_PMS];

  wol_out_gate gate_i (
    .clk         (clk),
    .rst         (rst),
    .match_nxt_i (flag_nxt[IDX_MATCH]),
    .wint_nxt_i  (flag_nxt[IDX_WINT]),
    .pms_nxt_i   (flag_nxt[IDX_PMS]),
    .pme_en_i    (pme_en_i),
    .pme_ovr_i   (pme_ovr_i),
    .irq_en_i    (irq_en_i),
    .wint_en_i   (wint_en_i),
    .led_sel_i   (led_sel_i),
    .led_pol_i   (led_pol_i),
    .pme_o       (pme_o),
    .irq_o       (irq_o),
    .led_o       (led_o)
  );

  // Arming, the pause held for the engines, and the discard pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      wake_armed_o <= 1'b0;
      pause_o      <= 1'b0;
      frame_drop_o <= 1'b0;
    end else begin
      wake_armed_o <= wake_en_i & ~pwr_good_i & low_ok;
      pause_o      <= (pause_o | hit) & ~release_req;
      frame_drop_o <= hit;
    end
  end

  AST_ARM_NEEDS_LOW_TIME: assert property (@(posedge clk) disable iff (rst)
    !low_ok |=> !wake_armed_o); // R9

  AST_HIT_DROPS_FRAME: assert property (@(posedge clk) disable iff (rst)
    hit |=> frame_drop_o); // R7

  AST_NO_DROP_UNARMED: assert property (@(posedge clk) disable iff (rst)
    !hit |=> !frame_drop_o); // R7

  AST_PAUSE_SET: assert property (@(posedge clk) disable iff (rst)
    (hit && !release_req) |=> pause_o); // R8

  AST_PAUSE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    release_req |=> !pause_o); // R8

endmodule

// File: tb/wol_event_ctrl_tb_top.sv
`timescale 1ns/1ps
module wol_event_ctrl_tb_top;

  localparam int MIN_CYC = 50; // 200 ns at a 4 ns clock

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wake_en = 0, pwr_good = 0, det = 0;
  logic clr_m = 0, clr_w = 0, clr_p = 0;
  logic pe = 0, po = 0, gie = 0, wie = 0, sel = 0, pol = 0;
  logic match_f, wint_f, pms_f, pme, irq, led, drop, pause, armed;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  wol_event_ctrl dut_i (
    .clk(clk), .rst(rst), .wake_en_i(wake_en), .pwr_good_i(pwr_good),
    .det_pulse_i(det), .clr_match_i(clr_m), .clr_wint_i(clr_w),
    .clr_pms_i(clr_p), .pme_en_i(pe), .pme_ovr_i(po), .irq_en_i(gie),
    .wint_en_i(wie), .led_sel_i(sel), .led_pol_i(pol),
    .match_flag_o(match_f), .wint_flag_o(wint_f), .pms_flag_o(pms_f),
    .pme_o(pme), .irq_o(irq), .led_o(led), .frame_drop_o(drop),
    .pause_o(pause), .wake_armed_o(armed)
  );

  // Expected-state model built from the requirements.
  int         m_cnt = 0;
  logic       m_armed = 0, m_pause = 0, m_drop = 0;
  logic       m_pme = 0, m_irq = 0, m_led = 0;
  logic [2:0] m_flags = '0;

  logic [8:0] exp_q[$];
  string      phase_q[$];
  string      field_name[9] = '{"match", "wint", "pms", "pme", "irq", "led",
                                "drop", "pause", "armed"};
  string      field_req[9]  = '{"R2", "R2", "R2", "R4", "R5", "R6", "R7",
                                "R8", "R9"};

  task automatic cyc(input string ph);
    logic       hit;
    logic       act;
    logic [2:0] clr;
    @(posedge clk);
    if (rst) begin
      m_cnt = 0; m_armed = 0; m_pause = 0; m_drop = 0;
      m_pme = 0; m_irq = 0; m_led = 0; m_flags = '0;
    end else begin
      hit     = m_armed & det;
      clr     = {clr_p, clr_w, clr_m};
      m_flags = (m_flags & ~clr) | {3{hit}};
      m_pause = (m_pause | hit) & wake_en & ~pwr_good;
      m_drop  = hit;
      m_pme   = m_flags[2] & (pe | po);
      m_irq   = m_flags[1] & gie & wie;
      act     = sel & m_flags[0];
      m_led   = pol ? act : ~act;
      m_armed = wake_en & ~pwr_good & (m_cnt == MIN_CYC);
      if (pwr_good) m_cnt = 0;
      else if (m_cnt != MIN_CYC) m_cnt = m_cnt + 1;
    end
    exp_q.push_back({m_armed, m_pause, m_drop, m_led, m_irq, m_pme, m_flags});
    phase_q.push_back(ph);
    @(negedge clk);
    #0.5;
  endtask

  task automatic run(input int n, input string ph);
    for (int i = 0; i < n; i++) cyc(ph);
  endtask

  // Monitor: compares each queued expectation half a cycle after its edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [8:0] e;
      logic [8:0] a;
      string      ph;
      e  = exp_q.pop_front();
      ph = phase_q.pop_front();
      a  = {armed, pause, drop, led, irq, pme, pms_f, wint_f, match_f};
      for (int b = 0; b < 9; b++) begin
        checks++;
        if (a[b] !== e[b]) begin
          fails++;
          $display("FAIL %s [%s] %s got %b exp %b", field_req[b], ph,
                   field_name[b], a[b], e[b]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired got running exp finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    run(3, "R1 reset state");
    rst = 0; wake_en = 1; pwr_good = 0;
    run(MIN_CYC + 2, "R9 first arming");
    det = 1; run(1, "R2 armed detect");
    det = 0; run(1, "R7 drop pulse ends");
    pe = 1; run(1, "R4 event enable");
    pe = 0; po = 1; run(1, "R4 override enable");
    po = 0; run(1, "R4 both off");
    gie = 1; run(1, "R5 global enable only");
    wie = 1; run(1, "R5 both enables");
    gie = 0; run(1, "R5 global off");
    sel = 1; pol = 0; run(1, "R6 active low");
    pol = 1; run(1, "R6 active high");
    sel = 0; run(1, "R6 deselected");
    clr_m = 1; run(1, "R3 clear match");
    clr_m = 0; clr_w = 1; clr_p = 1; run(1, "R3 clear others");
    clr_w = 0; clr_p = 0; run(1, "R3 flags stay clear");
    clr_m = 1; clr_w = 1; clr_p = 1; det = 1; pe = 1;
    run(1, "R3 clear with detect");
    clr_m = 0; clr_w = 0; clr_p = 0; det = 0; run(2, "R3 sticky hold");
    pwr_good = 1; run(2, "R8 power-good release");
    pwr_good = 0; run(10, "R9 short low");
    pwr_good = 1; run(1, "R9 restart");
    pwr_good = 0; run(MIN_CYC + 2, "R9 full low period");
    det = 1; run(1, "R8 pause set");
    det = 0; run(3, "R8 pause hold");
    wake_en = 0; run(2, "R8 software release");
    det = 1; run(1, "R2 detect ignored when disarmed");
    det = 0; wake_en = 1; run(2, "R10 software re-arm");
    det = 1; pwr_good = 1; run(1, "R8 release wins");
    det = 0; pwr_good = 0; run(2, "R8 after release");
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule